// File: doc/BRIEF.md
# Serial ADC Port Emulator

This block is a synthesizable stand-in for the digital side of a two-input successive-approximation converter with a three-wire serial port. It is meant to sit in an FPGA test fixture in place of the real converter. The host under test drives the convert strobe, the shift clock and the configuration data line. All three are brought into a fast system clock through synchronisers. The emulator takes one unsigned sample value per input channel from parallel ports. These values are in LSB units and are one bit wider than the result, so over-range values can be represented.

A rising convert strobe latches a 16-bit unipolar code, formed from the channel pairing selected earlier. The port then stays busy for a fixed number of system cycles. After that it either sleeps, if the strobe is still high, or opens a read frame, if the strobe has dropped. During a frame the result leaves most significant bit first, one bit per falling shift clock, and zeros follow once the word is exhausted. At the same time the first two configuration bits are collected on rising shift clocks. These two bits choose the pairing for the following conversion. The output has a separate drive-enable so the fixture can model a tri-state pin.

Top module: `sar_port_emu`

## Requirements
- R1: After reset the mode output reads sleeping (2), the data output is not driven (enable 0), and the pairing in force is channel 0 single-ended (selector 2'b10). That pairing is used by the first conversion if no selector has been loaded.
- R2: A rising convert strobe puts the mode output to converting (1) with the output disabled for exactly CONV_CYCLES system cycles. If the strobe is still high when they end, the mode becomes sleeping (2).
- R3: When the strobe falls after the busy time, or the busy time ends with the strobe already low, the mode becomes sampling (0). The output is enabled and shows the result's bit 15. A strobe that falls during the busy time does not shorten it.
- R4: Each falling shift clock in a frame advances the output by one bit, so after k falls it shows bit 15-k. The first fall moves the mode from sampling (0) to shifting (3).
- R5: Once all 16 result bits have been sent, every further falling shift clock with the strobe low leaves the output at 0.
- R6: The configuration line is sampled on the first two rising shift clocks of a frame, selector bit 1 first. Later bits in the frame are ignored. The selector applies to the next conversion. A frame that carries fewer than two bits leaves the previous pairing in force.
- R7: Selector 2'b10 measures channel 0 against ground and 2'b11 measures channel 1 against ground. Selector 2'b00 measures channel 0 minus channel 1, and 2'b01 measures channel 1 minus channel 0.
- R8: The code equals the selected difference when it lies in 0..65535. A negative difference yields 0x0000, and a difference of 65536 or more yields 0xFFFF.
- R9: The channel values are taken at the conversion start. Changing them afterwards does not alter the result that is read out.
- R10: A rising strobe in the middle of a frame aborts the read at once (mode converting, output disabled). It starts a new conversion whose result is read in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert strobe from the host (asynchronous) |
| sck_i | input | 1 | Shift clock from the host (asynchronous) |
| sdi_i | input | 1 | Configuration data from the host (asynchronous) |
| ch0_i | input | IW | Channel 0 sample value, LSB units |
| ch1_i | input | IW | Channel 1 sample value, LSB units |
| sdo_o | output | 1 | Serial result bit (0 when not driven) |
| sdo_oe_o | output | 1 | Drive enable for the serial result |
| mode_o | output | 2 | 0 sampling, 1 converting, 2 sleeping, 3 shifting |

## Verification
A mistaken busy counter shows up on the mode output within one conversion time, either as a converting window of the wrong length or as a frame that never opens. A shift register that is loaded or advanced wrongly corrupts the first word read back. A missing zero fill shows up on the very first shift clock after bit 0. A fault in selector capture or commit is quieter: it only surfaces one conversion later, as the code of the wrong pairing. For that reason each frame both loads a new pairing and reads back the result of the previous one.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

  typedef enum logic [1:0] {
    MODE_SAMPLE  = 2'd0,
    MODE_CONVERT = 2'd1,
    MODE_SLEEP   = 2'd2,
    MODE_SHIFT   = 2'd3
  } mode_e;

  localparam int CFG_W = 2;
  typedef logic [CFG_W-1:0] mux_cfg_t;

  // selector values: bit 1 = single-ended, bit 0 = odd channel / swapped sign
  localparam mux_cfg_t SEL_CH0_GND = 2'b10;
  localparam mux_cfg_t SEL_CH1_GND = 2'b11;
  localparam mux_cfg_t SEL_0_MIN_1 = 2'b00;
  localparam mux_cfg_t SEL_1_MIN_0 = 2'b01;

  localparam mux_cfg_t CFG_AT_RESET = SEL_CH0_GND;

endpackage

// File: rtl/sar_sync_level.sv
module sar_sync_level #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sar_cfg_capture.sv
module sar_cfg_capture
  import sar_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,    // conversion start: adopt the pending selector
  input  logic     frame_en,  // a read frame is open
  input  logic     bit_stb,   // rising shift clock
  input  logic     bit_val,
  output mux_cfg_t cfg_next,  // pairing the starting conversion will use
  output mux_cfg_t cfg_act
);
  localparam int NW = $clog2(CFG_W + 1);

  mux_cfg_t        cap_sh;
  logic [NW-1:0]   cap_n;
  logic            cap_full;

  assign cap_full = (cap_n == NW'(CFG_W));
  assign cfg_next = cap_full ? cap_sh : cfg_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sh  <= '0;
      cap_n   <= '0;
      cfg_act <= CFG_AT_RESET;
    end else if (commit) begin
      cfg_act <= cfg_next;
      cap_n   <= '0;
    end else if (frame_en && bit_stb && !cap_full) begin
      cap_sh <= {cap_sh[CFG_W-2:0], bit_val};
      cap_n  <= cap_n + 1'b1;
    end
  end
endmodule

// File: rtl/sar_code_former.sv
module sar_code_former
  import sar_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 17   // must exceed DW
) (
  input  mux_cfg_t        sel,
  input  logic [IW-1:0]   ch0,
  input  logic [IW-1:0]   ch1,
  output logic [DW-1:0]   code
);
  function automatic logic signed [IW:0] pair_diff(input mux_cfg_t s,
                                                   input logic [IW-1:0] a,
                                                   input logic [IW-1:0] b);
    case (s)
      SEL_CH0_GND: return $signed({1'b0, a});
      SEL_CH1_GND: return $signed({1'b0, b});
      SEL_0_MIN_1: return $signed({1'b0, a}) - $signed({1'b0, b});
      default:     return $signed({1'b0, b}) - $signed({1'b0, a});
    endcase
  endfunction

  function automatic logic [DW-1:0] clamp_code(input logic signed [IW:0] d);
    if (d[IW])              return '0;
    if (|d[IW-1:DW])        return '1;
    return d[DW-1:0];
  endfunction

  assign code = clamp_code(pair_diff(sel, ch0, ch1));
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  output logic          msb
);
  logic [DW-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= load_val;
    else if (shift) sreg <= {sreg[DW-2:0], 1'b0};
  end

  assign msb = sreg[DW-1];
endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu
  import sar_port_pkg::*;
#(
  parameter int DW          = 16,
  parameter int IW          = 17,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic [IW-1:0] ch0_i,
  input  logic [IW-1:0] ch1_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [1:0]    mode_o
);
  localparam int NPIN  = 3;
  localparam int NEDGE = 2;
  localparam int PIN_CONV = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [NPIN-1:0]  pin_raw, pin_lvl;
  logic [NEDGE-1:0] pin_rise, pin_fall;

  assign pin_raw = {sdi_i, sck_i, conv_i};

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_sync
      sar_sync_level #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_raw[g]), .lvl(pin_lvl[g]));
    end
    for (g = 0; g < NEDGE; g++) begin : g_edge
      sar_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[g]),
        .rise(pin_rise[g]), .fall(pin_fall[g]));
    end
  endgenerate

  // named internal events
  logic conv_lvl, conv_rise, conv_fall, sck_rise, sck_fall;
  assign conv_lvl  = pin_lvl[PIN_CONV];
  assign conv_rise = pin_rise[PIN_CONV];
  assign conv_fall = pin_fall[PIN_CONV];
  assign sck_rise  = pin_rise[PIN_SCK];
  assign sck_fall  = pin_fall[PIN_SCK];

  mode_e         state;
  logic [CW-1:0] busy_cnt;
  logic          frame_open, load_stb, shift_stb, conv_done;

  assign frame_open = (state == MODE_SAMPLE) || (state == MODE_SHIFT);
  assign load_stb   = conv_rise && (state != MODE_CONVERT);
  assign shift_stb  = sck_fall && frame_open && !conv_rise;
  assign conv_done  = (state == MODE_CONVERT) && (busy_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MODE_SLEEP;
      busy_cnt <= '0;
    end else if (load_stb) begin
      state    <= MODE_CONVERT;
      busy_cnt <= CW'(CONV_CYCLES - 1);
    end else begin
      case (state)
        MODE_CONVERT: begin
          if (conv_done) state <= conv_lvl ? MODE_SLEEP : MODE_SAMPLE;
          else           busy_cnt <= busy_cnt - 1'b1;
        end
        MODE_SLEEP:  if (conv_fall) state <= MODE_SAMPLE;
        MODE_SAMPLE: if (sck_fall)  state <= MODE_SHIFT;
        default:     state <= state;
      endcase
    end
  end

  mux_cfg_t      cfg_next, cfg_act;
  logic [DW-1:0] code_now;
  logic          bit_out;

  sar_cfg_capture u_cfg (
    .clk(clk), .rst_n(rst_n), .commit(load_stb), .frame_en(frame_open),
    .bit_stb(sck_rise), .bit_val(pin_lvl[PIN_SDI]),
    .cfg_next(cfg_next), .cfg_act(cfg_act));

  sar_code_former #(.DW(DW), .IW(IW)) u_code (
    .sel(cfg_next), .ch0(ch0_i), .ch1(ch1_i), .code(code_now));

  sar_shift_out #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_stb), .load_val(code_now),
    .shift(shift_stb), .msb(bit_out));

  assign sdo_oe_o = frame_open;
  assign sdo_o    = frame_open & bit_out;
  assign mode_o   = state;
endmodule

// File: rtl/sar_port_chk.sv
module sar_port_chk
  import sar_port_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       conv_rise,
  input logic       sck_fall,
  input logic       load,
  input mux_cfg_t   cfg_act
);
  localparam int RW = $clog2(CONV_CYCLES + 1) + 1;
  localparam int FW = $clog2(DW) + 2;

  logic [RW-1:0] run_n;
  logic [FW-1:0] fall_n;
  logic          in_frame;

  assign in_frame = (mode == MODE_SAMPLE) || (mode == MODE_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_n  <= '0;
      fall_n <= '0;
    end else begin
      run_n <= (mode == MODE_CONVERT) ? run_n + 1'b1 : '0;
      if (load)
        fall_n <= '0;
      else if (sck_fall && in_frame && !conv_rise && fall_n < FW'(DW))
        fall_n <= fall_n + 1'b1;
    end
  end

  // R2: a conversion start makes the port busy with the output released
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode == MODE_CONVERT) && !sdo_oe);

  // R2: the busy window never exceeds the conversion time
  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CONVERT) |-> (run_n < RW'(CONV_CYCLES)));

  // R3: the busy window ends after exactly the conversion time
  a_r3_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_CONVERT) && (run_n == RW'(CONV_CYCLES - 1))) |=> (mode != MODE_CONVERT));

  // R4: the first falling shift clock moves sampling to shifting
  a_r4_first_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SAMPLE) && sck_fall && !conv_rise) |=> (mode == MODE_SHIFT));

  // R5: once the word is exhausted the line stays low
  a_r5_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_n >= FW'(DW)) && sdo_oe) |-> !sdo);

  // R6: the pairing in force changes only at a conversion start
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_act));

  // R10: a strobe during shifting aborts the frame
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SHIFT) && conv_rise) |=> (mode == MODE_CONVERT) && !sdo_oe);
endmodule

bind sar_port_emu sar_port_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_o), .sdo(sdo_o), .sdo_oe(sdo_oe_o),
  .conv_rise(conv_rise), .sck_fall(sck_fall), .load(load_stb), .cfg_act(cfg_act));

// File: tb/sim_sar_port_emu.sv
`timescale 1ns/1ps
module sim_sar_port_emu;
  localparam int DW = 16;
  localparam int IW = 17;
  localparam int CONV_CYCLES = 40;
  localparam int HP = 6;      // shift clock half period in system cycles
  localparam int NV = 10;

  // {selector[1:0], ch0[16:0], ch1[16:0], expected code[15:0]}
  localparam logic [51:0] VEC [NV] = '{
    {2'b10, 17'h01234, 17'h0FFFF, 16'h1234},   // R7 ch0 vs ground
    {2'b11, 17'h01234, 17'h0ABCD, 16'hABCD},   // R7 ch1 vs ground
    {2'b00, 17'h08000, 17'h03000, 16'h5000},   // R7 ch0 - ch1
    {2'b01, 17'h08000, 17'h03000, 16'h0000},   // R8 negative clamps
    {2'b01, 17'h00100, 17'h0FFFF, 16'hFEFF},   // R7 ch1 - ch0
    {2'b10, 17'h10000, 17'h00000, 16'hFFFF},   // R8 full scale clamps
    {2'b11, 17'h00000, 17'h1FFFF, 16'hFFFF},   // R8 far over range
    {2'b00, 17'h05555, 17'h05555, 16'h0000},   // R8 zero difference
    {2'b00, 17'h10000, 17'h00001, 16'hFFFF},   // R8 one below full scale
    {2'b10, 17'h0FFFF, 17'h00000, 16'hFFFF}    // R8 top code, no clamp
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [IW-1:0] ch0 = '0, ch1 = '0;
  logic sdo, sdo_oe;
  logic [1:0] mode;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_port_emu #(.DW(DW), .IW(IW), .CONV_CYCLES(CONV_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .ch0_i(ch0), .ch1_i(ch1), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mode_o(mode));

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sck(input logic b);
    sdi = b; sck = 1'b1; wait_clk(HP);
    sck = 1'b0; wait_clk(HP);
  endtask

  task automatic run_frame(input logic [1:0] sel, input int nclk,
                           output logic [DW-1:0] word, output int tail);
    word = '0; tail = 0;
    for (int i = 0; i < nclk; i++) begin
      if (i < 2) sdi = sel[1-i];
      else       sdi = i[0];           // later bits must be ignored
      if (i < DW) word[DW-1-i] = sdo;
      else if (sdo !== 1'b0) tail++;
      sck = 1'b1; wait_clk(HP);
      sck = 1'b0; wait_clk(HP);
    end
    sdi = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] w;
    int tl;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    expect_eq("R1", "mode after reset", mode, 2);
    expect_eq("R1", "enable after reset", sdo_oe, 0);

    // first conversion uses the reset pairing (ch0 vs ground)
    ch0 = 17'h08777; ch1 = 17'h00333;
    conv = 1'b1; wait_clk(CONV_CYCLES + HP + 4);
    expect_eq("R2", "sleep with strobe high", mode, 2);
    conv = 1'b0; wait_clk(HP);
    expect_eq("R3", "sampling after fall", mode, 0);
    expect_eq("R3", "enable after fall", sdo_oe, 1);
    expect_eq("R3", "bit 15 before clocks", sdo, 1);
    run_frame(VEC[0][51:50], DW + 3, w, tl);
    expect_eq("R1", "default pairing code", w, 16'h8777);
    expect_eq("R5", "zero tail", tl, 0);

    // table walk: each frame reads one result and loads the next pairing
    for (int v = 0; v < NV; v++) begin
      logic [1:0] nsel;
      ch0 = VEC[v][49:33]; ch1 = VEC[v][32:16];
      conv = 1'b1; wait_clk(HP + 2);
      ch0 = ~VEC[v][49:33]; ch1 = ~VEC[v][32:16];   // R9 late change
      wait_clk(CONV_CYCLES + 4);
      conv = 1'b0; wait_clk(HP);
      nsel = (v < NV - 1) ? VEC[v+1][51:50] : 2'b11;
      run_frame(nsel, DW + 3, w, tl);
      expect_eq("R6 R7 R8 R9", $sformatf("vector %0d code", v), w, VEC[v][15:0]);
      expect_eq("R5", $sformatf("vector %0d tail", v), tl, 0);
    end

    // busy window timing, pairing now ch1 vs ground
    ch1 = 17'h0ABCD;
    conv = 1'b1; wait_clk(HP);
    expect_eq("R2", "converting", mode, 1);
    expect_eq("R2", "released while busy", sdo_oe, 0);
    wait_clk(CONV_CYCLES - 2 * HP);
    expect_eq("R2", "still converting", mode, 1);
    wait_clk(2 * HP + 4);
    expect_eq("R2", "sleep after busy", mode, 2);
    conv = 1'b0; wait_clk(HP);
    expect_eq("R4", "sampling before first fall", mode, 0);
    pulse_sck(1'b1);
    expect_eq("R4", "shifting after first fall", mode, 3);
    expect_eq("R4", "bit 14", sdo, 0);
    pulse_sck(1'b1);
    expect_eq("R4", "bit 13", sdo, 1);
    pulse_sck(1'b0); pulse_sck(1'b0);

    // abort mid-frame; selector 11 from the aborted frame applies
    ch1 = 17'h04321;
    conv = 1'b1; wait_clk(HP);
    expect_eq("R10", "abort to converting", mode, 1);
    expect_eq("R10", "abort releases output", sdo_oe, 0);
    wait_clk(CONV_CYCLES + 4);
    conv = 1'b0; wait_clk(HP);
    run_frame(2'b00, DW + 2, w, tl);
    expect_eq("R10", "code after abort", w, 16'h4321);

    // pairing 00 in force; a one-bit frame must not change it
    ch0 = 17'h09000; ch1 = 17'h01000;
    conv = 1'b1; wait_clk(CONV_CYCLES + HP + 4);
    conv = 1'b0; wait_clk(HP);
    run_frame(2'b01, 1, w, tl);

    // early strobe fall during the busy time
    conv = 1'b1; wait_clk(10);
    conv = 1'b0; wait_clk(10);
    expect_eq("R3", "early fall keeps busy", mode, 1);
    expect_eq("R3", "early fall output off", sdo_oe, 0);
    wait_clk(CONV_CYCLES);
    expect_eq("R3", "sampling at busy end", mode, 0);
    expect_eq("R3", "enabled at busy end", sdo_oe, 1);
    expect_eq("R3", "bit 15 at busy end", sdo, 1);
    run_frame(2'b10, DW + 2, w, tl);
    expect_eq("R6", "short frame keeps pairing", w, 16'h8000);
    expect_eq("R5", "tail after short test", tl, 0);

    done = 1'b1;
    summary();
  end
endmodule